// File: doc/BRIEF.md
# Legal-Trace Acceptor for a Two-State Mealy Machine

This block watches the input bit and the output bit of a small two-state Mealy machine and decides, one clock at a time, whether the pairs seen since reset form a legal trace of that machine. Each pair is one letter, written as the input bit followed by the output bit. A letter is taken only in a cycle where `letter_valid` is high. The acceptor follows the machine's two states with two accepting states of its own. Any letter the machine could not have produced sends it to a single rejecting state, and it stays there until reset.

The result is a level, not a pulse. `accept` is high while the letters consumed so far form an accepted word. `error` is high once an illegal letter has been seen. The outputs depend only on the current state, so they change one clock after the edge that takes the letter. The empty word counts as accepted, so `accept` is high out of reset.

Top module: `trace_acceptor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the acceptor returns to its home state. From the next cycle on, `accept` is 1 and `error` is 0.
- R2: In the home state, a valid letter 00 (input 0, output 0) keeps the acceptor in the home state and `accept` stays 1.
- R3: In the home state, a valid letter 11 (input 1, output 1) moves the acceptor to the marked state and `accept` stays 1.
- R4: In the marked state, a valid letter 10 (input 1, output 0) keeps the acceptor in the marked state and `accept` stays 1.
- R5: In the marked state, a valid letter 00 returns the acceptor to the home state and `accept` stays 1.
- R6: A valid letter 01 (input 0, output 1) is illegal in every state. It moves the acceptor to the sink, where `accept` is 0 and `error` is 1 from the next cycle.
- R7: A valid letter 10 in the home state is illegal and leads to the sink. A valid letter 11 in the marked state is illegal and leads to the sink.
- R8: The sink is absorbing. No letter, legal or not, takes the acceptor out of it; only reset does.
- R9: In a cycle with `letter_valid` low, the state does not change, whatever values are present on `mach_in` and `mach_out`.
- R10: `accept` and `error` are always complements of each other. Both reflect the state after the most recent letter, one clock after the edge that takes it.
- R11: Starting from reset, the word 00.00.11.10.10.10.00.11 ends accepted and the word 00.01 ends rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| letter_valid | input | 1 | High when `mach_in` and `mach_out` carry a letter to consume |
| mach_in | input | 1 | Observed input bit of the monitored machine (first letter bit) |
| mach_out | input | 1 | Observed output bit of the monitored machine (second letter bit) |
| accept | output | 1 | High while the word consumed so far is accepted |
| error | output | 1 | High while the acceptor is in the sink |

## Verification
Two functions of this block can land in the same cycle. The first is the hold that an idle cycle imposes. The second is the detection of an illegal code. The bench provokes the overlap by putting the illegal code 01 on the pins with `letter_valid` low, in both the home and the marked state. It then sends a letter that is legal in only one of those states, which shows whether the hidden state survived. A second overlap occurs in the sink, where legal letters arrive and must not lift `error`. A behavioural model in the bench predicts `accept` and `error` for every clock, and the bench compares them half a cycle after each edge.

// File: rtl/trace_acc_pkg.sv
// Package: shared types and letter codes for the trace acceptor.
// Assumes a letter is {input bit, output bit} of the monitored machine.
package trace_acc_pkg;
    localparam int LETTER_W = 2;

    typedef logic [LETTER_W-1:0] letter_t;

    localparam letter_t CODE_REST = 2'b00;  // input 0, output 0
    localparam letter_t CODE_BAD  = 2'b01;  // input 0, output 1 (never legal)
    localparam letter_t CODE_HOLD = 2'b10;  // input 1, output 0
    localparam letter_t CODE_FIRE = 2'b11;  // input 1, output 1

    typedef enum logic [1:0] {
        ST_HOME = 2'd0,
        ST_MARK = 2'd1,
        ST_SINK = 2'd2
    } acc_state_e;
endpackage

// File: rtl/trace_letter_decode.sv
// Module: sorts one observed letter into the three legal classes.
// Assumes the letter is formed as {input bit, output bit}. A letter that
// matches no class is illegal; the next-state logic treats it by default.
module trace_letter_decode
    import trace_acc_pkg::*;
(
    input  logic    letter_valid,
    input  letter_t letter,
    output logic    take_rest,
    output logic    take_hold,
    output logic    take_fire
);
    // Qualify each legal class with the valid strobe.
    always_comb begin
        take_rest = letter_valid && (letter == CODE_REST);
        take_hold = letter_valid && (letter == CODE_HOLD);
        take_fire = letter_valid && (letter == CODE_FIRE);
    end
endmodule

// File: rtl/trace_next_state.sv
// Module: transition function of the acceptor.
// Assumes the take_* inputs are mutually exclusive and already qualified by
// letter_valid. Any valid letter without a legal move leads to the sink,
// and so does the unused state code.
module trace_next_state
    import trace_acc_pkg::*;
(
    input  acc_state_e cur,
    input  logic       letter_valid,
    input  logic       take_rest,
    input  logic       take_hold,
    input  logic       take_fire,
    output acc_state_e nxt
);
    // Select the successor state for the current letter.
    always_comb begin
        nxt = cur;
        if (letter_valid) begin
            unique case (cur)
                ST_HOME: begin
                    if (take_rest)      nxt = ST_HOME;
                    else if (take_fire) nxt = ST_MARK;
                    else                nxt = ST_SINK;
                end
                ST_MARK: begin
                    if (take_hold)      nxt = ST_MARK;
                    else if (take_rest) nxt = ST_HOME;
                    else                nxt = ST_SINK;
                end
                default: nxt = ST_SINK;
            endcase
        end
    end
endmodule

// File: rtl/trace_state_reg.sv
// Module: state register with synchronous active-low reset to home.
// Assumes rst_n is synchronous to clk.
module trace_state_reg
    import trace_acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  acc_state_e nxt,
    output acc_state_e cur
);
    // Capture the next state; reset returns to the home state.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_HOME;
        else        cur <= nxt;
    end
endmodule

// File: rtl/trace_acceptor.sv
// Module: top of the trace acceptor. It checks that the observed
// {input, output} letters form a legal trace of a two-state Mealy machine.
// Assumes one letter per cycle in which letter_valid is high. The outputs
// depend only on the state, so they appear one clock after the letter.
module trace_acceptor
    import trace_acc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic letter_valid,
    input  logic mach_in,
    input  logic mach_out,
    output logic accept,
    output logic error
);
    letter_t    letter;
    logic       take_rest;
    logic       take_hold;
    logic       take_fire;
    acc_state_e state_nx;
    acc_state_e state_q;

    assign letter = {mach_in, mach_out};

    trace_letter_decode u_decode (
        .letter_valid (letter_valid),
        .letter       (letter),
        .take_rest    (take_rest),
        .take_hold    (take_hold),
        .take_fire    (take_fire)
    );

    trace_next_state u_next (
        .cur          (state_q),
        .letter_valid (letter_valid),
        .take_rest    (take_rest),
        .take_hold    (take_hold),
        .take_fire    (take_fire),
        .nxt          (state_nx)
    );

    trace_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (state_nx),
        .cur   (state_q)
    );

    // Decode the visible verdict from the current state.
    always_comb begin
        error  = (state_q == ST_SINK);
        accept = !error;
    end
endmodule

// File: rtl/trace_acceptor_chk.sv
// Module: temporal checks on the acceptor, attached through bind.
// Assumes cur_state is the acceptor's registered state.
module trace_acceptor_chk
    import trace_acc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       letter_valid,
    input logic       mach_in,
    input logic       mach_out,
    input logic       accept,
    input logic       error,
    input acc_state_e cur_state
);
    assert_bad_letter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (letter_valid && !mach_in && mach_out) |=> (error && !accept));

    assert_sink_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !letter_valid |=> $stable(cur_state));

    assert_fire_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_HOME && letter_valid && mach_in && mach_out)
        |=> (cur_state == ST_MARK));

    assert_rest_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_MARK && letter_valid && !mach_in && !mach_out)
        |=> (cur_state == ST_HOME));

    assert_mark_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_MARK && letter_valid && mach_in && !mach_out)
        |=> (cur_state == ST_MARK && accept));
endmodule

bind trace_acceptor trace_acceptor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .letter_valid (letter_valid),
    .mach_in      (mach_in),
    .mach_out     (mach_out),
    .accept       (accept),
    .error        (error),
    .cur_state    (state_q)
);

// File: tb/trace_acceptor_test.sv
// Bench: behavioural reference model compared with the outputs every clock.
module trace_acceptor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic letter_valid = 1'b0;
    logic mach_in = 1'b0;
    logic mach_out = 1'b0;
    logic accept;
    logic error;

    int checks = 0;
    int fails = 0;
    int model = 0;  // 0 home, 1 marked, 2 sink
    bit done = 1'b0;

    always #5 clk = ~clk;

    trace_acceptor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .letter_valid (letter_valid),
        .mach_in      (mach_in),
        .mach_out     (mach_out),
        .accept       (accept),
        .error        (error)
    );

    task automatic compare(input string tag);
        logic exp_acc;
        exp_acc = (model != 2);
        checks++;
        if (accept !== exp_acc || error !== !exp_acc) begin
            fails++;
            $display("FAIL %s: accept=%b error=%b expected accept=%b error=%b",
                     tag, accept, error, exp_acc, !exp_acc);
        end
    endtask

    // One clock: drive at the falling edge, model the edge, compare at the next fall.
    task automatic step(input bit v, input bit i, input bit o, input string tag);
        @(negedge clk);
        letter_valid = v; mach_in = i; mach_out = o;
        @(posedge clk);
        if (v) begin
            if (model == 0)      model = ({i, o} == 2'b00) ? 0 : ({i, o} == 2'b11) ? 1 : 2;
            else if (model == 1) model = ({i, o} == 2'b10) ? 1 : ({i, o} == 2'b00) ? 0 : 2;
        end
        @(negedge clk);
        letter_valid = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; letter_valid = 1'b1; mach_in = 1'b0; mach_out = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model = 0;
        compare(tag);
        rst_n = 1'b1; letter_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        // R11 accepted word, covering R2 R3 R4 R5
        step(1, 0, 0, "R2 rest in home");
        step(1, 0, 0, "R2 rest in home");
        step(1, 1, 1, "R3 fire to marked");
        step(1, 1, 0, "R4 hold in marked");
        step(1, 1, 0, "R4 hold in marked");
        step(1, 1, 0, "R4 hold in marked");
        step(1, 0, 0, "R5 return home");
        step(1, 1, 1, "R11 word ends accepted");
        // R9 idle with illegal code on pins while marked, then 10 proves marked
        step(0, 0, 1, "R9 idle in marked");
        step(0, 1, 1, "R9 idle in marked");
        step(1, 1, 0, "R9 marked survived idle");
        step(1, 0, 0, "R5 return home");
        // R9 idle while home, then 00 proves home
        step(0, 0, 1, "R9 idle in home");
        step(0, 1, 0, "R9 idle in home");
        step(1, 0, 0, "R9 home survived idle");
        // R6 illegal letter from home, then R8 absorption
        step(1, 0, 1, "R6 bad letter in home");
        step(1, 0, 0, "R8 sink absorbs 00");
        step(1, 1, 1, "R8 sink absorbs 11");
        step(1, 1, 0, "R8 sink absorbs 10");
        step(0, 0, 0, "R8 sink with idle");
        do_reset("R1 reset leaves sink");
        step(1, 0, 0, "R11 short word first letter");
        step(1, 0, 1, "R11 word 00.01 rejected");
        do_reset("R1 reset");
        step(1, 1, 0, "R7 10 in home");
        do_reset("R1 reset");
        step(1, 1, 1, "R3 fire to marked");
        step(1, 1, 1, "R7 11 in marked");
        do_reset("R1 reset");
        step(1, 1, 1, "R3 fire to marked");
        step(1, 0, 1, "R6 bad letter in marked");
        step(1, 0, 0, "R10 verdict stays rejected");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule